// File: doc/BRIEF.md
# Endpoint Configuration Header

This block holds the configuration-space registers of a single endpoint function. A host reaches it through a simple access port. Each access carries a dword index into the 4 KiB configuration region of the function. Reads return a full dword one clock later. Writes carry four byte enables and change only the enabled bytes of fields that can be written.

The header carries fixed identification and class fields and a small command register. It also holds six base address registers, each sized by a parameter. The low bits of each register, up to its size, cannot be written, and neither can its attribute bits. Software finds the size of a region by writing all ones to the register and reading it back.

A capability pointer leads to a short chain of two capability entries. The block drives the current base addresses and the three enable bits from the command register to the rest of the function.

Top module: `epcfg_header`

## Requirements
- R1: The dword at byte offset 0x00 reads the vendor identifier in bits 15:0 and the device identifier in bits 31:16. Writes to it are ignored.
- R2: Command bits 0, 1 and 2 at offset 0x04 are the memory, I/O and bus-master enables. They reset to zero and are driven on `memEnable`, `ioEnable` and `busMasterEnable`. The other command bits read zero.
- R3: The base registers sit at offsets 0x10 + 4*n for n = 0..5. For a region of 2^k bytes, bits k-1:0 ignore writes. Writing 0xFFFFFFFF and reading back gives a value whose inverse plus one, after the attribute bits are cleared, equals 2^k.
- R4: Attribute bits are read-only. An I/O register reads bit 0 = 1 and bit 1 = 0. A memory register reads bit 0 = 0, bits 2:1 = 00 (32-bit decoder) and bit 3 = prefetchable.
- R5: A base register whose size parameter is zero is not implemented. It always reads zero and drives a zero base.
- R6: A write changes only the bytes whose enable is set (enable bit j covers data bits 8j+7:8j).
- R7: Offset 0x34 bits 7:0 read 0x40, the head of the capability chain. Status bit 4 (bit 20 of dword 0x04) reads one to show that the chain exists.
- R8: Offset 0x40 reads capability ID 0x01 in bits 7:0 and next pointer 0x50 in bits 15:8. Offset 0x50 reads ID 0x05 with next pointer 0x00, which ends the chain.
- R9: Any other offset in the 4 KiB region reads zero. Writes to such an offset change no register.
- R10: `cfgRdValid` is high exactly one cycle after each `cfgRdEn`, with the data in `cfgRdData`. Without a read it is low.
- R11: `barBase` slice n (bits 32n+31:32n) carries the writable address bits of base register n, with the attribute bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRdEn | input | 1 | Read strobe |
| cfgWrEn | input | 1 | Write strobe |
| cfgAddr | input | 10 | Dword index (byte offset bits 11:2) |
| cfgWrData | input | 32 | Write data |
| cfgByteEn | input | 4 | Write byte enables |
| cfgRdData | output | 32 | Read data, valid with cfgRdValid |
| cfgRdValid | output | 1 | Read data valid |
| barBase | output | 192 | Six 32-bit decoded base addresses |
| memEnable | output | 1 | Memory decode enable |
| ioEnable | output | 1 | I/O decode enable |
| busMasterEnable | output | 1 | Bus-master enable |

## Verification
The assertions assume that a read and a write are never requested in the same cycle. They also assume that every size parameter is zero, or at least 4 for memory and 2 for I/O, and below 32. The stimulus drives one access per cycle, either a read or a write. The bench instantiates the block with sizes inside those limits, including 16 bytes, the smallest memory region allowed. Byte-enable patterns cover full, single-lane and no-lane writes, so the assertions on held registers get exercised.

// File: rtl/epcfg_pkg.sv
package epcfg_pkg;
  localparam int NUM_BARS = 6;
  localparam int DW = 32;
  localparam int ADDR_W = 10;
  localparam int LOG2_W = 6;

  // dword indices of decoded registers
  localparam logic [ADDR_W-1:0] ID_DW      = 10'd0;
  localparam logic [ADDR_W-1:0] CMD_DW     = 10'd1;
  localparam logic [ADDR_W-1:0] CLASS_DW   = 10'd2;
  localparam logic [ADDR_W-1:0] BAR0_DW    = 10'd4;
  localparam logic [ADDR_W-1:0] CAPPTR_DW  = 10'd13;

  localparam logic [7:0] CAP_A_OFS = 8'h40;
  localparam logic [7:0] CAP_B_OFS = 8'h50;
  localparam logic [7:0] CAP_A_ID  = 8'h01;
  localparam logic [7:0] CAP_B_ID  = 8'h05;
  localparam logic [ADDR_W-1:0] CAP_A_DW = ADDR_W'(CAP_A_OFS >> 2);
  localparam logic [ADDR_W-1:0] CAP_B_DW = ADDR_W'(CAP_B_OFS >> 2);

  localparam logic [15:0] STATUS_VAL = 16'h0010;

  typedef enum logic [2:0] {
    RD_ZERO, RD_ID, RD_CMDSTAT, RD_CLASS, RD_BAR, RD_CAPPTR, RD_CAP_A, RD_CAP_B
  } rdSel_e;

  typedef struct packed {
    logic                cmdWr;
    logic [NUM_BARS-1:0] barWr;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [2:0]          barIdx;
  } strobes_t;
endpackage

// File: rtl/epcfg_ctrl.sv
module epcfg_ctrl
  import epcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  logic [ADDR_W-1:0] barOfs;
  logic              inBarRange;

  assign barOfs     = addr - BAR0_DW;
  assign inBarRange = (addr >= BAR0_DW) && (addr < BAR0_DW + ADDR_W'(NUM_BARS));

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdEn;
    stb.rdSel  = RD_ZERO;
    stb.barIdx = '0;
    if (inBarRange) begin
      stb.rdSel  = RD_BAR;
      stb.barIdx = barOfs[2:0];
      stb.barWr[barOfs[2:0]] = wrEn;
    end else begin
      case (addr)
        ID_DW:     stb.rdSel = RD_ID;
        CMD_DW: begin
          stb.rdSel = RD_CMDSTAT;
          stb.cmdWr = wrEn;
        end
        CLASS_DW:  stb.rdSel = RD_CLASS;
        CAPPTR_DW: stb.rdSel = RD_CAPPTR;
        CAP_A_DW:  stb.rdSel = RD_CAP_A;
        CAP_B_DW:  stb.rdSel = RD_CAP_B;
        default:   stb.rdSel = RD_ZERO;
      endcase
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdWr, stb.barWr})); // R9

  AST_NO_WRITE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ({stb.cmdWr, stb.barWr} == '0)); // R9
endmodule

// File: rtl/epcfg_dp.sv
module epcfg_dp
  import epcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1AB4,
  parameter logic [15:0] DEVICE_ID = 16'h0C21,
  parameter logic [31:0] CLASS_REV = 32'h0200_0001,
  parameter logic [NUM_BARS*LOG2_W-1:0] BAR_SIZE_LOG2 = {6'd0, 6'd4, 6'd0, 6'd20, 6'd8, 6'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO       = 6'b000010,
  parameter logic [NUM_BARS-1:0] BAR_PREFETCH = 6'b000100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [DW-1:0]          wrData,
  input  logic [3:0]             byteEn,
  output logic [DW-1:0]          rdData,
  output logic                   rdValid,
  output logic [NUM_BARS*DW-1:0] barBaseFlat,
  output logic [2:0]             cmdBits
);
  logic [DW-1:0] laneMask;
  logic [DW-1:0] barReg  [NUM_BARS];
  logic [DW-1:0] barRead [NUM_BARS];
  logic [2:0]    cmdReg;
  logic [DW-1:0] rdMux;

  assign laneMask = {{8{byteEn[3]}}, {8{byteEn[2]}}, {8{byteEn[1]}}, {8{byteEn[0]}}};

  always_ff @(posedge clk) begin
    if (!rstN) cmdReg <= '0;
    else if (stb.cmdWr && byteEn[0]) cmdReg <= wrData[2:0];
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam int L = int'(BAR_SIZE_LOG2[i*LOG2_W +: LOG2_W]);
    if (L == 0) begin : g_absent
      assign barReg[i]  = '0;
      assign barRead[i] = '0;
    end else begin : g_present
      localparam logic [DW-1:0] WMASK = ~((32'd1 << L) - 32'd1);
      localparam logic [DW-1:0] ATTR  = BAR_IO[i] ? 32'h1 :
                                        (BAR_PREFETCH[i] ? 32'h8 : 32'h0);
      always_ff @(posedge clk) begin
        if (!rstN) barReg[i] <= '0;
        else if (stb.barWr[i])
          barReg[i] <= ((barReg[i] & ~laneMask) | (wrData & laneMask)) & WMASK;
      end
      assign barRead[i] = barReg[i] | ATTR;

      AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !stb.barWr[i] |=> $stable(barReg[i])); // R3
      AST_BAR_LANE3_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (stb.barWr[i] && !byteEn[3]) |=> $stable(barReg[i][31:24])); // R6
    end
    assign barBaseFlat[i*DW +: DW] = barReg[i];
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdSel)
      RD_ID:      rdMux = {DEVICE_ID, VENDOR_ID};
      RD_CMDSTAT: rdMux = {STATUS_VAL, 13'd0, cmdReg};
      RD_CLASS:   rdMux = CLASS_REV;
      RD_BAR:     if (int'(stb.barIdx) < NUM_BARS) rdMux = barRead[stb.barIdx];
      RD_CAPPTR:  rdMux = {24'd0, CAP_A_OFS};
      RD_CAP_A:   rdMux = {16'd0, CAP_B_OFS, CAP_A_ID};
      RD_CAP_B:   rdMux = {16'd0, 8'h00, CAP_B_ID};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      rdData  <= stb.rdEn ? rdMux : '0;
    end
  end

  assign cmdBits = cmdReg;

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> rdValid); // R10
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> !rdValid); // R10
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmdWr |=> $stable(cmdReg)); // R2
endmodule

// File: rtl/epcfg_header.sv
module epcfg_header
  import epcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1AB4,
  parameter logic [15:0] DEVICE_ID = 16'h0C21,
  parameter logic [31:0] CLASS_REV = 32'h0200_0001,
  parameter logic [NUM_BARS*LOG2_W-1:0] BAR_SIZE_LOG2 = {6'd0, 6'd4, 6'd0, 6'd20, 6'd8, 6'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO       = 6'b000010,
  parameter logic [NUM_BARS-1:0] BAR_PREFETCH = 6'b000100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgRdEn,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [DW-1:0]          cfgWrData,
  input  logic [3:0]             cfgByteEn,
  output logic [DW-1:0]          cfgRdData,
  output logic                   cfgRdValid,
  output logic [NUM_BARS*DW-1:0] barBase,
  output logic                   memEnable,
  output logic                   ioEnable,
  output logic                   busMasterEnable
);
  strobes_t   stb;
  logic [2:0] cmdBits;

  epcfg_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .rdEn (cfgRdEn),
    .wrEn (cfgWrEn),
    .addr (cfgAddr),
    .stb  (stb)
  );

  epcfg_dp #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .CLASS_REV     (CLASS_REV),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2),
    .BAR_IO        (BAR_IO),
    .BAR_PREFETCH  (BAR_PREFETCH)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (cfgWrData),
    .byteEn      (cfgByteEn),
    .rdData      (cfgRdData),
    .rdValid     (cfgRdValid),
    .barBaseFlat (barBase),
    .cmdBits     (cmdBits)
  );

  assign memEnable       = cmdBits[0];
  assign ioEnable        = cmdBits[1];
  assign busMasterEnable = cmdBits[2];
endmodule

// File: tb/epcfg_header_tb_top.sv
module epcfg_header_tb_top;
  localparam logic [15:0] VEN = 16'h1AB4;
  localparam logic [15:0] DEV = 16'h0C21;
  localparam logic [31:0] CLS = 32'h0200_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRdEn = 1'b0, cfgWrEn = 1'b0;
  logic [9:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic [191:0] barBase;
  logic        memEnable, ioEnable, busMasterEnable;

  always #5 clk = ~clk;

  epcfg_header #(
    .VENDOR_ID (VEN), .DEVICE_ID (DEV), .CLASS_REV (CLS),
    .BAR_SIZE_LOG2 ({6'd0, 6'd4, 6'd0, 6'd20, 6'd8, 6'd12}),
    .BAR_IO (6'b000010), .BAR_PREFETCH (6'b000100)
  ) dut_i (.*);

  // reference model state
  int          sizeLog2 [6] = '{12, 8, 20, 0, 4, 0};
  bit          isIo     [6] = '{0, 1, 0, 0, 0, 0};
  bit          isPref   [6] = '{0, 0, 1, 0, 0, 0};
  logic [31:0] mBar [6];
  logic [2:0]  mCmd;
  logic        mRdValid;
  logic [31:0] mRdData;
  string       curReq = "R10";
  int nChecks = 0, nFails = 0;
  bit done = 0;

  function automatic logic [31:0] attrOf(int i);
    if (sizeLog2[i] == 0) return 32'h0;
    if (isIo[i]) return 32'h1;
    return isPref[i] ? 32'h8 : 32'h0;
  endfunction

  function automatic logic [31:0] modelRead(logic [9:0] a);
    int ofs = int'(a) * 4;
    if (ofs >= 'h10 && ofs <= 'h24) begin
      int n = (ofs - 'h10) / 4;
      return mBar[n] | attrOf(n);
    end
    case (ofs)
      'h00: return {DEV, VEN};
      'h04: return {16'h0010, 13'd0, mCmd};
      'h08: return CLS;
      'h34: return 32'h40;
      'h40: return 32'h0000_5001;
      'h50: return 32'h0000_0005;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R10 valid", {31'd0, cfgRdValid}, {31'd0, mRdValid});
    if (mRdValid) chk(curReq, cfgRdData, mRdData);
    for (int i = 0; i < 6; i++) chk("R11 base", barBase[i*32 +: 32], mBar[i]);
    chk("R2 enables", {29'd0, busMasterEnable, ioEnable, memEnable}, {29'd0, mCmd});
  endtask

  task automatic doWrite(int ofs, logic [31:0] d, logic [3:0] be);
    logic [31:0] lm;
    lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    cfgRdEn = 0; cfgWrEn = 1; cfgAddr = 10'(ofs / 4); cfgWrData = d; cfgByteEn = be;
    mRdValid = 0;
    if (ofs >= 'h10 && ofs <= 'h24) begin
      int n = (ofs - 'h10) / 4;
      logic [31:0] wm;
      wm = (sizeLog2[n] == 0) ? 32'h0 : ~((32'd1 << sizeLog2[n]) - 32'd1);
      mBar[n] = ((mBar[n] & ~lm) | (d & lm)) & wm;
    end else if (ofs == 'h04 && be[0]) begin
      mCmd = d[2:0];
    end
    tick();
  endtask

  task automatic doRead(int ofs, string req);
    cfgWrEn = 0; cfgRdEn = 1; cfgAddr = 10'(ofs / 4); cfgByteEn = 0;
    curReq = req;
    mRdValid = 1;
    mRdData = modelRead(10'(ofs / 4));
    tick();
  endtask

  task automatic idle();
    cfgWrEn = 0; cfgRdEn = 0; mRdValid = 0;
    tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 6; i++) mBar[i] = '0;
    mCmd = '0; mRdValid = 0; mRdData = '0;
    // R2 reset state, compared while reset is held
    repeat (3) tick();
    rstN = 1;
    idle();

    // R1 identification, writes ignored
    doRead('h00, "R1 id");
    doWrite('h00, 32'hFFFF_FFFF, 4'hF);
    doRead('h00, "R1 id after write");

    // R2 command enables, R7 status bit
    doRead('h04, "R2 cmd reset");
    doWrite('h04, 32'hFFFF_FFFF, 4'h3);
    doRead('h04, "R2 cmd set R7");
    doWrite('h04, 32'h0000_0000, 4'hE);   // R6 lane 0 disabled: no change
    doRead('h04, "R6 cmd lane hold");
    doWrite('h04, 32'h0000_0002, 4'h1);
    doRead('h04, "R2 cmd io only");

    // R7 / R8 capability chain
    doRead('h34, "R7 cap head");
    doRead('h40, "R8 cap first");
    doRead('h50, "R8 cap last");

    // R3 R4 R5 sizing on every base register
    for (int i = 0; i < 6; i++) begin
      doWrite('h10 + 4*i, 32'hFFFF_FFFF, 4'hF);
      doRead('h10 + 4*i, sizeLog2[i] == 0 ? "R5 absent" : "R3 R4 sizing");
      if (sizeLog2[i] != 0) begin
        logic [31:0] lowMask, sz;
        lowMask = isIo[i] ? 32'h3 : 32'hF;
        sz = ~(cfgRdData & ~lowMask) + 32'd1;
        chk("R3 size", sz, 32'd1 << sizeLog2[i]);
        chk("R4 attr", cfgRdData & lowMask, attrOf(i));
      end
    end

    // R11 address programming, R6 partial writes
    doWrite('h10, 32'hA5A5_5FFF, 4'hF);
    doWrite('h14, 32'h0000_C3FF, 4'hF);
    doWrite('h18, 32'hFEDC_BA98, 4'hF);
    doWrite('h20, 32'h8765_432F, 4'hF);
    doRead('h10, "R11 bar0");
    doWrite('h18, 32'h1234_5678, 4'h4);
    doRead('h18, "R6 bar2 lane2");
    doWrite('h20, 32'h0000_0000, 4'h0);
    doRead('h20, "R6 no lanes");
    doWrite('h20, 32'h0000_00F0, 4'h1);
    doRead('h20, "R6 bar4 lane0");

    // R9 unimplemented offsets
    doWrite('h28, 32'hFFFF_FFFF, 4'hF);
    doWrite('h3C, 32'hFFFF_FFFF, 4'hF);
    doWrite('h100, 32'hFFFF_FFFF, 4'hF);
    doWrite('hFFC, 32'hFFFF_FFFF, 4'hF);
    doRead('h28, "R9 0x28");
    doRead('h0C, "R9 0x0C");
    doRead('h3C, "R9 0x3C");
    doRead('h100, "R9 0x100");
    doRead('hFFC, "R9 0xFFC");
    for (int i = 0; i < 6; i++) doRead('h10 + 4*i, "R9 bars unchanged");
    doRead('h04, "R9 cmd unchanged");

    // R10 back-to-back and idle
    doRead('h08, "R10 class");
    doRead('h00, "R10 back to back");
    idle();
    idle();
    finishRun();
  end
endmodule